// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block buffers data words between two unrelated clock domains. A producer pushes words on the write clock, and a consumer pops them on the read clock into a registered output. Each port is gated by two enables. A push needs its first enable low and its second enable high. A pop needs both of its enables low. A push is dropped while the buffer is full, and a pop is dropped while it is empty.

Four active-low status flags report how full the buffer is. The full and almost-full flags are produced in the write domain. The empty and almost-empty flags are produced in the read domain. The two almost thresholds come from offset values driven in by a separate offset block, which holds 7 for both after reset.

The pointers cross between domains in gray code through flop synchronizers. As a result, each flag asserts on the edge of the access that causes it, but deasserts a few cycles after the opposite side has acted. The three-state output is modelled as a data bus together with a drive qualifier. While the output enable is inactive, the data bus reads as zero.

Top module: `fifo_dual_clk_pf`

## Requirements
- R1: A word is stored on a rising write-clock edge only when `wr_en1_n` is 0 and `wr_en2` is 1. Any other combination stores nothing and leaves the flags unchanged.
- R2: A pop happens on a rising read-clock edge only when `rd_en1_n` and `rd_en2_n` are both 0. With either of them at 1, the output register keeps its value.
- R3: While `full_n` is 0, pushes are ignored. With no pops after reset, `full_n` falls on the edge of push number DEPTH.
- R4: While `empty_n` is 0, pops are ignored, and the output register keeps its value.
- R5: While `rst` is 1 (synchronous, sampled on each clock), the pointers clear, the output register clears to zero, `full_n` and `afull_n` are 1, and `empty_n` and `aempty_n` are 0.
- R6: Once settled, `aempty_n` is 0 when the stored count is at most `empty_off`, and 1 when the count is `empty_off`+1 or more.
- R7: Once settled, `afull_n` is 0 when the count is at least DEPTH−`full_off`, and 1 below that.
- R8: When `oe_n` is 1, `rd_data` is all zeros and `rd_data_vld` is 0. When `oe_n` is 0, `rd_data` carries the output register and `rd_data_vld` is 1.
- R9: Words leave in the order they were accepted, each exactly once. A pop presents its word at the output on the read edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| wr_en1_n | input | 1 | Write enable, active low |
| wr_en2 | input | 1 | Write enable, active high |
| wr_data | input | WIDTH | Word to push |
| rd_en1_n | input | 1 | Read enable, active low |
| rd_en2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output drive enable, active low |
| empty_off | input | AW | Almost-empty offset n |
| full_off | input | AW | Almost-full offset m |
| rd_data | output | WIDTH | Registered output word, zero while not driven |
| rd_data_vld | output | 1 | Qualifier: rd_data is being driven |
| empty_n | output | 1 | Empty flag, read domain, active low |
| aempty_n | output | 1 | Almost-empty flag, read domain, active low |
| full_n | output | 1 | Full flag, write domain, active low |
| afull_n | output | 1 | Almost-full flag, write domain, active low |

## Verification
The assertions rely on two input conditions. Both offsets must stay below DEPTH, and they may change only while the flags are allowed to settle. The assertions also rely on `rst` being held for several edges of both clocks.

The stimulus respects these conditions. It alternates bursts of pushes and bursts of pops, and lets the synchronizers settle between bursts. Offsets change only between bursts. Because of this, the expected flag values follow from a count kept in the bench, and the late deassertion of a flag never shows up as a mismatch.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    localparam int GW = 32;

    typedef struct packed {
        logic full_n;
        logic afull_n;
    } wr_flags_t;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rd_flags_t;

    function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/fifo_pf_wr_ctrl.sv
module fifo_pf_wr_ctrl
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en1_n,
    input  logic          en2,
    input  logic [AW-1:0] full_off,
    input  logic [PW-1:0] rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output wr_flags_t     flags
);
    logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx, afull_thr;

    always_comb begin
        we        = !en1_n && en2 && flags.full_n;
        wbin_nx   = wbin + PW'(we);
        rbin_s    = PW'(gray2bin(GW'(rgray_s)));
        cnt_nx    = wbin_nx - rbin_s;
        afull_thr = PW'(DEPTH) - PW'(full_off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            flags <= '{full_n: 1'b1, afull_n: 1'b1};
        end else begin
            wbin          <= wbin_nx;
            wgray         <= PW'(bin2gray(GW'(wbin_nx)));
            flags.full_n  <= cnt_nx < PW'(DEPTH);
            flags.afull_n <= cnt_nx < afull_thr;
        end
    end

    assign waddr = wbin[AW-1:0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wbin - rbin_s) <= PW'(DEPTH)); // R3
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!flags.full_n && !en1_n && en2) |=> wbin == $past(wbin)); // R3
    AST_AFULL_COVERS_FULL: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |-> !flags.afull_n); // R7
    AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1); // R9
endmodule

// File: rtl/fifo_pf_rd_ctrl.sv
module fifo_pf_rd_ctrl
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en1_n,
    input  logic          en2_n,
    input  logic [AW-1:0] empty_off,
    input  logic [PW-1:0] wgray_s,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output rd_flags_t     flags
);
    logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;

    always_comb begin
        re      = !en1_n && !en2_n && flags.empty_n;
        rbin_nx = rbin + PW'(re);
        wbin_s  = PW'(gray2bin(GW'(wgray_s)));
        cnt_nx  = wbin_s - rbin_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            flags <= '{empty_n: 1'b0, aempty_n: 1'b0};
        end else begin
            rbin           <= rbin_nx;
            rgray          <= PW'(bin2gray(GW'(rbin_nx)));
            flags.empty_n  <= cnt_nx != '0;
            flags.aempty_n <= cnt_nx > PW'(empty_off);
        end
    end

    assign raddr = rbin[AW-1:0];

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wbin_s - rbin) <= PW'(DEPTH)); // R4
    AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!flags.empty_n && !en1_n && !en2_n) |=> rbin == $past(rbin)); // R4
    AST_AEMPTY_COVERS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !flags.empty_n |-> !flags.aempty_n); // R6
    AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1); // R9
endmodule

// File: rtl/fifo_pf_mem.sv
module fifo_pf_mem #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 9,
    parameter int AW    = 10
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_clk,
    input  logic             rst,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (rst)     q <= '0;
        else if (re) q <= store[raddr];
    end

    AST_Q_HOLDS: assert property (@(posedge rd_clk) disable iff (rst)
        !re |=> $stable(q)); // R2
endmodule

// File: rtl/fifo_dual_clk_pf.sv
module fifo_dual_clk_pf
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int WIDTH       = 9,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst,
    input  logic             wr_en1_n,
    input  logic             wr_en2,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en1_n,
    input  logic             rd_en2_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    empty_off,
    input  logic [AW-1:0]    full_off,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_data_vld,
    output logic             empty_n,
    output logic             aempty_n,
    output logic             full_n,
    output logic             afull_n
);
    logic             we, re;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
    logic [WIDTH-1:0] q;
    wr_flags_t        wfl;
    rd_flags_t        rfl;

    fifo_pf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk(wr_clk), .rst(rst), .en1_n(wr_en1_n), .en2(wr_en2),
        .full_off(full_off), .rgray_s(rgray_s), .we(we), .waddr(waddr),
        .wgray(wgray), .flags(wfl)
    );

    fifo_pf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .clk(rd_clk), .rst(rst), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
        .empty_off(empty_off), .wgray_s(wgray_s), .re(re), .raddr(raddr),
        .rgray(rgray), .flags(rfl)
    );

    fifo_pf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s)
    );

    fifo_pf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
    );

    fifo_pf_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst(rst), .re(re), .raddr(raddr), .q(q)
    );

    assign rd_data     = oe_n ? '0 : q;
    assign rd_data_vld = !oe_n;
    assign full_n      = wfl.full_n;
    assign afull_n     = wfl.afull_n;
    assign empty_n     = rfl.empty_n;
    assign aempty_n    = rfl.aempty_n;
endmodule

// File: tb/tb_fifo_dual_clk_pf.sv
module tb_fifo_dual_clk_pf;
    localparam int DEPTH = 32;
    localparam int WIDTH = 9;
    localparam int AW    = 5;

    logic             wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
    logic             wr_en1_n = 1'b1, wr_en2 = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
    logic [AW-1:0]    empty_off = 5'd7, full_off = 5'd7;
    logic [WIDTH-1:0] rd_data;
    logic             rd_data_vld, empty_n, aempty_n, full_n, afull_n;

    int               n_tests = 0, n_fail = 0;
    int               n_off = 7, m_off = 7;
    logic [WIDTH-1:0] model_q [$];
    logic [WIDTH-1:0] last_q = '0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    fifo_dual_clk_pf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
        .wr_en1_n(wr_en1_n), .wr_en2(wr_en2), .wr_data(wr_data),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
        .empty_off(empty_off), .full_off(full_off),
        .rd_data(rd_data), .rd_data_vld(rd_data_vld),
        .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_full_n(int c);   return c < DEPTH;         endfunction
    function automatic bit exp_afull_n(int c);  return c < DEPTH - m_off; endfunction
    function automatic bit exp_empty_n(int c);  return c != 0;            endfunction
    function automatic bit exp_aempty_n(int c); return c > n_off;         endfunction

    task automatic check_flags();
        int c = model_q.size();
        chk(full_n == exp_full_n(c), "R3 full_n", full_n, exp_full_n(c));
        chk(afull_n == exp_afull_n(c), "R7 afull_n", afull_n, exp_afull_n(c));
        chk(empty_n == exp_empty_n(c), "R4 empty_n", empty_n, exp_empty_n(c));
        chk(aempty_n == exp_aempty_n(c), "R6 aempty_n", aempty_n, exp_aempty_n(c));
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
        repeat (2) @(negedge rd_clk);
        check_flags();
    endtask

    // called at a negedge of wr_clk
    task automatic do_write(input bit e1n, input bit e2, input logic [WIDTH-1:0] d);
        bit    take = !e1n && e2 && (model_q.size() < DEPTH);
        string tag  = (e1n || !e2) ? "R1" : "R3";
        int    c;
        wr_en1_n = e1n; wr_en2 = e2; wr_data = d;
        @(posedge wr_clk);
        @(negedge wr_clk);
        if (take) model_q.push_back(d);
        wr_en1_n = 1'b1; wr_en2 = 1'b0;
        c = model_q.size();
        chk(full_n == exp_full_n(c), {tag, " full_n after push"}, full_n, exp_full_n(c));
        chk(afull_n == exp_afull_n(c), "R7 afull_n after push", afull_n, exp_afull_n(c));
    endtask

    // called at a negedge of rd_clk
    task automatic do_read(input bit e1n, input bit e2n);
        bit    take = !e1n && !e2n && (model_q.size() > 0);
        string tag  = take ? "R9" : ((e1n || e2n) ? "R2" : "R4");
        int    c;
        rd_en1_n = e1n; rd_en2_n = e2n;
        @(posedge rd_clk);
        @(negedge rd_clk);
        if (take) last_q = model_q.pop_front();
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        c = model_q.size();
        chk(rd_data == last_q, {tag, " rd_data"}, rd_data, last_q);
        chk(empty_n == exp_empty_n(c), "R4 empty_n after pop", empty_n, exp_empty_n(c));
        chk(aempty_n == exp_aempty_n(c), "R6 aempty_n after pop", aempty_n, exp_aempty_n(c));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R5: reset state
        repeat (5) @(negedge rd_clk);
        chk(full_n == 1'b1, "R5 full_n", full_n, 1);
        chk(afull_n == 1'b1, "R5 afull_n", afull_n, 1);
        chk(empty_n == 1'b0, "R5 empty_n", empty_n, 0);
        chk(aempty_n == 1'b0, "R5 aempty_n", aempty_n, 0);
        chk(rd_data == '0, "R5 rd_data", rd_data, 0);
        rst = 1'b0;
        settle();

        // R1: disabled enable patterns store nothing
        @(negedge wr_clk);
        do_write(1'b1, 1'b1, 9'h1AA);
        do_write(1'b0, 1'b0, 9'h155);
        do_write(1'b1, 1'b0, 9'h0F0);
        settle();
        chk(empty_n == 1'b0, "R1 nothing stored", empty_n, 0);

        // R6 boundary: n words then n+1
        @(negedge wr_clk);
        for (int i = 0; i < 7; i++) do_write(1'b0, 1'b1, WIDTH'(i + 1));
        settle();
        chk(aempty_n == 1'b0, "R6 at n words", aempty_n, 0);
        @(negedge wr_clk);
        do_write(1'b0, 1'b1, 9'h100);
        settle();
        chk(aempty_n == 1'b1, "R6 at n+1 words", aempty_n, 1);

        // R3/R7: fill to DEPTH, then push while full
        @(negedge wr_clk);
        while (model_q.size() < DEPTH) do_write(1'b0, 1'b1, WIDTH'($urandom));
        chk(full_n == 1'b0, "R3 full after DEPTH pushes", full_n, 0);
        do_write(1'b0, 1'b1, 9'h1FF);
        do_write(1'b0, 1'b1, 9'h1FE);
        settle();

        // R2: disabled pops hold the output
        @(negedge rd_clk);
        do_read(1'b1, 1'b0);
        do_read(1'b0, 1'b1);
        do_read(1'b0, 1'b0);
        do_read(1'b1, 1'b1);

        // R8: drive qualifier
        oe_n = 1'b1;
        #1;
        chk(rd_data == '0, "R8 rd_data undriven", rd_data, 0);
        chk(rd_data_vld == 1'b0, "R8 vld low", rd_data_vld, 0);
        oe_n = 1'b0;
        #1;
        chk(rd_data == last_q, "R8 rd_data driven", rd_data, last_q);
        chk(rd_data_vld == 1'b1, "R8 vld high", rd_data_vld, 1);

        // drain with random enables, then pops while empty (R4)
        @(negedge rd_clk);
        while (model_q.size() > 0) do_read(($urandom % 4) == 0, ($urandom % 4) == 0);
        do_read(1'b0, 1'b0);
        do_read(1'b0, 1'b0);
        settle();

        // new offsets, random bursts
        n_off = 3; m_off = 5;
        empty_off = 5'd3; full_off = 5'd5;
        settle();
        for (int r = 0; r < 30; r++) begin
            @(negedge wr_clk);
            for (int k = 0; k < int'($urandom_range(0, DEPTH)); k++)
                do_write(($urandom % 5) == 0, ($urandom % 5) != 0, WIDTH'($urandom));
            settle();
            @(negedge rd_clk);
            for (int k = 0; k < int'($urandom_range(0, DEPTH)); k++)
                do_read(($urandom % 5) == 0, ($urandom % 5) == 0);
            settle();
        end

        @(negedge rd_clk);
        while (model_q.size() > 0) do_read(1'b0, 1'b0);
        settle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule